// File: doc/BRIEF.md
# Security-Gated Interrupt State Registers

This block keeps three per-interrupt state vectors (enable, pending and active) for the shared interrupts of an interrupt controller. Each 32-bit register word covers 32 interrupts. Software reaches the vectors through a single-request register port. Every request carries a secure flag. Each vector has two apertures: writing ones through a set aperture raises bits, and writing ones through a clear aperture drops them. Zeros written to either aperture change nothing.

A non-secure request touches only the bits it is permitted to touch, unless the security-disable input is high. A bit is permitted when its interrupt's group bit is 1. It is also permitted when the interrupt's two-bit non-secure grant field is high enough for the register being accessed. Reads are masked the same way, so bits that are not permitted read as zero.

The block also watches one external input line per shared interrupt. A one-bit trigger configuration per interrupt marks it as edge-sensitive or level-sensitive. A rising line latches the pending bit of an edge-sensitive interrupt. For a level-sensitive interrupt, the line level itself is added to the pending view.

Top module: `irq_gate_regs`

## Requirements
- R1: Byte address bits [ADDR_W-1:7] select an aperture: 0 group, 1 enable-set, 2 enable-clear, 3 pending-set, 4 pending-clear, 5 active-set, 6 active-clear, 7 trigger configuration (bit=1 means edge). Byte addresses 0x400 to 0x4FF hold the grant words. Within an aperture, byte offset k covers interrupts 8k to 8k+31 (bit i is interrupt 8k+i).
- R2: A word whose first interrupt is below 32 or at or above NUM_IRQ reads as zero and ignores writes. Grant words whose index is below 2 or at or above NUM_IRQ/16 follow the same rule.
- R3: A set aperture ORs (data AND mask) into the vector. A clear aperture ANDs the vector with NOT (data AND mask). Data bits at zero leave the stored bit unchanged.
- R4: A request is restricted when it is non-secure and sec_disable is 0. For a restricted request, the mask is the group word ORed with a grant-derived mask. Enable, active-write and trigger apertures add no grant mask. For all other requests the mask is all ones.
- R5: The grant for interrupt n is the two bits at position 2*(n mod 16) of grant word n/16, at byte 0x400 + 4*(n/16). The value 0 grants nothing. The value 1 or more grants pending-set reads and writes. The value 2 or more also grants pending-clear reads and writes and active reads.
- R6: A pending read returns (latch OR (line level AND NOT edge)) ANDed with the mask.
- R7: A 0-to-1 line change latches pending only for an edge interrupt. A steady level latches nothing. When a line edge and a pending-clear of the same bit are accepted on one clock edge, the latch ends set.
- R8: The group aperture reads as zero and ignores writes for restricted requests. Grant words are readable and writable only when the request is secure and sec_disable is 0; otherwise they read as zero and ignore writes.
- R9: A read accepted on one clock edge gives rsp_valid and rsp_rdata on the next. Writes give no response. Addresses outside every aperture read as zero.
- R10: en_o and act_o show the stored vectors, and pend_o shows the merged pending view of R6 without the mask. All three are zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_disable | input | 1 | 1 = single security state, no masking |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure request |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_lines | input | NUM_IRQ | External interrupt input lines |
| en_o | output | NUM_IRQ | Enable vector |
| pend_o | output | NUM_IRQ | Merged pending view |
| act_o | output | NUM_IRQ | Active vector |

## Verification
The enable aperture is exercised with secure set and clear writes over overlapping bit patterns, which separates OR-in and clear-out from plain replacement. A non-secure write of all ones then shows that only group bits pass, and the same write with sec_disable high shows the mask opening fully. Interrupts with grant values 1, 2 and 3 are read and written through the pending-set, pending-clear and active apertures. This separates the two grant thresholds from each other and from the group path. Line stimulus covers a level pulse, an edge pulse, a clear while the line stays high, and a clear on the same edge as a rise, which together tell latch behaviour from level merging.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   localparam int WORD_W         = 32;
   localparam int FIRST_SHARED   = 32;
   localparam int FIELD_PER_WORD = WORD_W / 2;

   typedef enum logic [3:0] {
      RG_GROUP    = 4'd0,
      RG_EN_SET   = 4'd1,
      RG_EN_CLR   = 4'd2,
      RG_PEND_SET = 4'd3,
      RG_PEND_CLR = 4'd4,
      RG_ACT_SET  = 4'd5,
      RG_ACT_CLR  = 4'd6,
      RG_EDGE     = 4'd7,
      RG_ACCESS   = 4'd8,
      RG_NONE     = 4'd15
   } reg_grp_e;

endpackage

// File: rtl/irq_gate_perm.sv
module irq_gate_perm
   import irq_gate_pkg::*;
(
   input  logic              restrict_i,
   input  logic [WORD_W-1:0] grp_i,
   input  logic [WORD_W-1:0] acc_lo_i,
   input  logic [WORD_W-1:0] acc_hi_i,
   output logic [WORD_W-1:0] m_grp_o,
   output logic [WORD_W-1:0] m_ge1_o,
   output logic [WORD_W-1:0] m_ge2_o
);

   logic [WORD_W-1:0] ge1;
   logic [WORD_W-1:0] ge2;

   // two grant words cover one 32-interrupt bitmap word
   for (genvar i = 0; i < FIELD_PER_WORD; i++) begin : g_field
      assign ge1[i]                  = acc_lo_i[2*i] | acc_lo_i[2*i+1];
      assign ge2[i]                  = acc_lo_i[2*i+1];
      assign ge1[FIELD_PER_WORD + i] = acc_hi_i[2*i] | acc_hi_i[2*i+1];
      assign ge2[FIELD_PER_WORD + i] = acc_hi_i[2*i+1];
   end

   assign m_grp_o = restrict_i ? grp_i         : '1;
   assign m_ge1_o = restrict_i ? (grp_i | ge1) : '1;
   assign m_ge2_o = restrict_i ? (grp_i | ge2) : '1;

endmodule

// File: rtl/irq_gate_lines.sv
module irq_gate_lines #(
   parameter int NUM_IRQ = 96,
   parameter int FIRST   = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] lines_i,
   output logic [NUM_IRQ-1:0] lvl_o,
   output logic [NUM_IRQ-1:0] rise_o
);

   localparam logic [NUM_IRQ-1:0] SHARED = {{(NUM_IRQ-FIRST){1'b1}}, {FIRST{1'b0}}};

   logic [NUM_IRQ-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lines_i & SHARED;
   end

   assign lvl_o  = lvl_q;
   assign rise_o = lines_i & SHARED & ~lvl_q;

endmodule

// File: rtl/irq_gate_regs.sv
module irq_gate_regs
   import irq_gate_pkg::*;
#(
   parameter int NUM_IRQ = 96,
   parameter int ADDR_W  = 12
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_disable,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_secure,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WORD_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [WORD_W-1:0]  rsp_rdata,
   input  logic [NUM_IRQ-1:0] irq_lines,
   output logic [NUM_IRQ-1:0] en_o,
   output logic [NUM_IRQ-1:0] pend_o,
   output logic [NUM_IRQ-1:0] act_o
);

   localparam int NWORDS     = NUM_IRQ / WORD_W;
   localparam int NACC       = NUM_IRQ / FIELD_PER_WORD;
   localparam int FIRST_WORD = FIRST_SHARED / WORD_W;
   localparam int FIRST_ACC  = FIRST_SHARED / FIELD_PER_WORD;
   localparam int HI_W       = ADDR_W - 7;

   if ((NUM_IRQ % WORD_W) != 0 || NUM_IRQ < 2*FIRST_SHARED || NUM_IRQ > 1024) begin : g_bad_num
      $error("NUM_IRQ must be a multiple of 32 in 64..1024");
   end
   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must be at least 11");
   end

   // ---------------- state ----------------
   logic [NUM_IRQ-1:0]   en_q, pend_q, act_q, grp_q, edge_q;
   logic [2*NUM_IRQ-1:0] acc_q;
   logic [NUM_IRQ-1:0]   lvl, rise, eff_pend;

   irq_gate_lines #(.NUM_IRQ(NUM_IRQ), .FIRST(FIRST_SHARED)) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (irq_lines),
      .lvl_o   (lvl),
      .rise_o  (rise)
   );

   assign eff_pend = pend_q | (lvl & ~edge_q);

   // ---------------- decode ----------------
   logic [HI_W-1:0] hi;
   logic [4:0]      wsel;
   logic [5:0]      asel;
   reg_grp_e        grp_sel;
   logic            word_ok, acc_ok, restricted, acc_allowed;
   int unsigned     widx, aidx;
   logic            unused_addr_bits;

   assign hi               = req_addr[ADDR_W-1:7];
   assign wsel             = req_addr[6:2];
   assign asel             = req_addr[7:2];
   assign unused_addr_bits = ^req_addr[1:0];

   always_comb begin
      if (hi < HI_W'(8))            grp_sel = reg_grp_e'(hi[3:0]);
      else if ((hi >> 1) == HI_W'(4)) grp_sel = RG_ACCESS;
      else                          grp_sel = RG_NONE;
   end

   assign word_ok     = (int'(wsel) >= FIRST_WORD) && (int'(wsel) < NWORDS);
   assign acc_ok      = (int'(asel) >= FIRST_ACC)  && (int'(asel) < NACC);
   assign widx        = word_ok ? int'(wsel) : 0;
   assign aidx        = acc_ok  ? int'(asel) : 0;
   assign restricted  = !req_secure && !sec_disable;
   assign acc_allowed = req_secure && !sec_disable && acc_ok;

   // ---------------- permission masks ----------------
   logic [WORD_W-1:0] grp_w, en_w, act_w, edge_w, epend_w, acc_w;
   logic [WORD_W-1:0] m_grp, m_ge1, m_ge2;

   assign grp_w   = grp_q[widx*WORD_W +: WORD_W];
   assign en_w    = en_q[widx*WORD_W +: WORD_W];
   assign act_w   = act_q[widx*WORD_W +: WORD_W];
   assign edge_w  = edge_q[widx*WORD_W +: WORD_W];
   assign epend_w = eff_pend[widx*WORD_W +: WORD_W];
   assign acc_w   = acc_q[aidx*WORD_W +: WORD_W];

   irq_gate_perm u_perm (
      .restrict_i (restricted),
      .grp_i      (grp_w),
      .acc_lo_i   (acc_q[(2*widx)*WORD_W +: WORD_W]),
      .acc_hi_i   (acc_q[(2*widx+1)*WORD_W +: WORD_W]),
      .m_grp_o    (m_grp),
      .m_ge1_o    (m_ge1),
      .m_ge2_o    (m_ge2)
   );

   // ---------------- read mux ----------------
   logic [WORD_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      case (grp_sel)
         RG_GROUP:              rd_word = restricted ? '0 : grp_w;
         RG_EN_SET, RG_EN_CLR:  rd_word = en_w & m_grp;
         RG_PEND_SET:           rd_word = epend_w & m_ge1;
         RG_PEND_CLR:           rd_word = epend_w & m_ge2;
         RG_ACT_SET, RG_ACT_CLR: rd_word = act_w & m_ge2;
         RG_EDGE:               rd_word = edge_w & m_grp;
         default:               rd_word = '0;
      endcase
      if (grp_sel != RG_ACCESS && !word_ok) rd_word = '0;
      if (grp_sel == RG_ACCESS)             rd_word = acc_allowed ? acc_w : '0;
   end

   // ---------------- write placement ----------------
   logic [WORD_W-1:0]  wmask;
   logic [NUM_IRQ-1:0] place_bits, place_mask, place_data;
   logic               do_wr;

   always_comb begin
      case (grp_sel)
         RG_GROUP:                 wmask = restricted ? '0 : '1;
         RG_PEND_SET:              wmask = m_ge1;
         RG_PEND_CLR:              wmask = m_ge2;
         default:                  wmask = m_grp;
      endcase
   end

   assign do_wr      = req_valid && req_write && word_ok;
   assign place_mask = {{(NUM_IRQ-WORD_W){1'b0}}, wmask} << (widx*WORD_W);
   assign place_data = {{(NUM_IRQ-WORD_W){1'b0}}, req_wdata} << (widx*WORD_W);
   assign place_bits = place_mask & place_data;

   logic [NUM_IRQ-1:0] en_set_v, en_clr_v, pd_set_v, pd_clr_v, ac_set_v, ac_clr_v;
   logic [NUM_IRQ-1:0] grp_upd_v, edge_upd_v;

   assign en_set_v   = (do_wr && grp_sel == RG_EN_SET)   ? place_bits : '0;
   assign en_clr_v   = (do_wr && grp_sel == RG_EN_CLR)   ? place_bits : '0;
   assign pd_set_v   = (do_wr && grp_sel == RG_PEND_SET) ? place_bits : '0;
   assign pd_clr_v   = (do_wr && grp_sel == RG_PEND_CLR) ? place_bits : '0;
   assign ac_set_v   = (do_wr && grp_sel == RG_ACT_SET)  ? place_bits : '0;
   assign ac_clr_v   = (do_wr && grp_sel == RG_ACT_CLR)  ? place_bits : '0;
   assign grp_upd_v  = (do_wr && grp_sel == RG_GROUP)    ? place_mask : '0;
   assign edge_upd_v = (do_wr && grp_sel == RG_EDGE)     ? place_mask : '0;

   // ---------------- state update ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= '0;
         pend_q    <= '0;
         act_q     <= '0;
         grp_q     <= '0;
         edge_q    <= '0;
         acc_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         en_q   <= (en_q  | en_set_v) & ~en_clr_v;
         act_q  <= (act_q | ac_set_v) & ~ac_clr_v;
         // a line edge on the same clock as a clear leaves the latch set
         pend_q <= (pend_q & ~pd_clr_v) | pd_set_v | (rise & edge_q);
         grp_q  <= (grp_q  & ~grp_upd_v)  | (place_data & grp_upd_v);
         edge_q <= (edge_q & ~edge_upd_v) | (place_data & edge_upd_v);
         if (req_valid && req_write && grp_sel == RG_ACCESS && acc_allowed)
            acc_q[aidx*WORD_W +: WORD_W] <= req_wdata;
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
      end
   end

   assign en_o   = en_q;
   assign act_o  = act_q;
   assign pend_o = eff_pend;

endmodule

// File: rtl/irq_gate_regs_chk.sv
module irq_gate_regs_chk #(
   parameter int NUM_IRQ = 96,
   parameter int ADDR_W  = 12
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 sec_disable,
   input logic                 req_valid,
   input logic                 req_write,
   input logic                 req_secure,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 rsp_valid,
   input logic [31:0]          rsp_rdata,
   input logic [NUM_IRQ-1:0]   en_o,
   input logic [2*NUM_IRQ-1:0] acc_q
);

   logic             is_rd, is_wr;
   logic [ADDR_W-8:0] hi;

   assign is_rd = req_valid && !req_write;
   assign is_wr = req_valid &&  req_write;
   assign hi    = req_addr[ADDR_W-1:7];

   // R9: a read gets exactly one response on the next cycle
   a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid);
   a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rsp_valid);
   // R9: unmapped space reads zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && req_addr >= ADDR_W'(12'h500)) |=> (rsp_rdata == '0));
   // R3: a set write never drops an enable bit
   a_r3_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && hi == (ADDR_W-7)'(1)) |=> ((en_o & $past(en_o)) == $past(en_o)));
   // R3: a clear write never raises an enable bit
   a_r3_clear_only_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && hi == (ADDR_W-7)'(2)) |=> ((en_o & ~$past(en_o)) == '0));
   // R2: writes to the internal-interrupt word change nothing
   a_r2_internal_word: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && hi == (ADDR_W-7)'(1) && req_addr[6:2] == 5'd0) |=> $stable(en_o));
   // R8: grant words are locked unless secure with security active
   a_r8_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && (hi >> 1) == (ADDR_W-7)'(4) && !(req_secure && !sec_disable))
      |=> $stable(acc_q));

endmodule

bind irq_gate_regs irq_gate_regs_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sec_disable (sec_disable),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_secure  (req_secure),
   .req_addr    (req_addr),
   .rsp_valid   (rsp_valid),
   .rsp_rdata   (rsp_rdata),
   .en_o        (en_o),
   .acc_q       (acc_q)
);

// File: tb/irq_gate_regs_tb.sv
`timescale 1ns/1ps
module irq_gate_regs_tb;

   localparam int N  = 96;
   localparam int AW = 12;
   localparam real CLK_NS = 8.0;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          sec_disable = 0;
   logic          req_valid = 0, req_write = 0, req_secure = 0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;
   logic [N-1:0]  irq_lines = '0;
   logic [N-1:0]  en_o, pend_o, act_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_NS/2) clk = ~clk;

   irq_gate_regs #(.NUM_IRQ(N), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
      .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .irq_lines(irq_lines), .en_o(en_o), .pend_o(pend_o), .act_o(act_o)
   );

   // monitor: compare each response with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected response: got %h expected none", rsp_rdata);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string       t = tag_q.pop_front();
            if (rsp_rdata !== e) begin
               errors++;
               $display("FAIL %s: got %h expected %h", t, rsp_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic sec, input logic [31:0] d);
      @(posedge clk); #1;
      req_valid = 1; req_write = 1; req_secure = sec; req_addr = a; req_wdata = d;
      @(posedge clk); #1;
      req_valid = 0; req_write = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic sec, input logic [31:0] e,
                     input string t);
      @(posedge clk); #1;
      req_valid = 1; req_write = 0; req_secure = sec; req_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic chk(input logic [127:0] got, input logic [127:0] e, input string t);
      @(negedge clk);
      checks++;
      if (got !== e) begin
         errors++;
         $display("FAIL %s: got %h expected %h", t, got, e);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   function automatic logic [127:0] w1(input logic [31:0] v);
      return {64'h0, v, 32'h0};
   endfunction

   initial begin : watchdog
      #(CLK_NS * 150000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(1);
      // R10 reset state
      chk(en_o,   '0, "R10 enable after reset");
      chk(pend_o, '0, "R10 pending after reset");
      chk(act_o,  '0, "R10 active after reset");
      rd(12'h084, 1, 32'h0, "R10 enable word reads zero");

      // R3 set/clear semantics, R1 aperture aliasing
      wr(12'h084, 1, 32'h0000_00F0);
      rd(12'h084, 1, 32'h0000_00F0, "R3 first set");
      wr(12'h084, 1, 32'h0000_0F00);
      rd(12'h084, 1, 32'h0000_0FF0, "R3 set ORs in");
      wr(12'h104, 1, 32'h0000_0030);
      chk({31'h0, rsp_valid}, 128'h0, "R9 no response after write");
      rd(12'h104, 1, 32'h0000_0FC0, "R3 clear removes only ones, R1 clear alias");
      chk(en_o, w1(32'h0FC0), "R10 enable vector position R1");

      // R2 internal and unimplemented words
      wr(12'h080, 1, 32'hFFFF_FFFF);
      wr(12'h08C, 1, 32'hFFFF_FFFF);
      rd(12'h080, 1, 32'h0, "R2 internal word reads zero");
      rd(12'h08C, 1, 32'h0, "R2 word beyond NUM_IRQ reads zero");
      chk(en_o, w1(32'h0FC0), "R2 writes to invalid words ignored");

      // R8 group aperture, R4 non-secure masking
      wr(12'h004, 1, 32'h0000_FFFF);
      rd(12'h004, 0, 32'h0, "R8 group hidden from non-secure");
      wr(12'h004, 0, 32'h0);
      rd(12'h004, 1, 32'h0000_FFFF, "R8 non-secure group write ignored");
      wr(12'h084, 0, 32'hFFFF_FFFF);
      rd(12'h084, 1, 32'h0000_FFFF, "R4 non-secure set limited to group bits");
      sec_disable = 1;
      wr(12'h084, 0, 32'hFFFF_0000);
      rd(12'h084, 0, 32'hFFFF_FFFF, "R4 security disabled opens mask");
      sec_disable = 0;
      rd(12'h084, 0, 32'h0000_FFFF, "R4 non-secure enable read masked");

      // R5 grant fields: irq48=1, irq49=2, irq50=3 in grant word 3
      wr(12'h40C, 1, 32'h0000_0039);
      rd(12'h40C, 0, 32'h0, "R8 grant hidden from non-secure");
      wr(12'h40C, 0, 32'h0);
      rd(12'h40C, 1, 32'h0000_0039, "R8 non-secure grant write ignored");
      wr(12'h184, 0, 32'h000F_0000);
      rd(12'h184, 1, 32'h0007_0000, "R5 set-pending needs grant>=1");
      rd(12'h184, 0, 32'h0007_0000, "R5 non-secure set-pending read");
      rd(12'h204, 0, 32'h0006_0000, "R5 clear-pending read needs grant>=2");
      wr(12'h204, 0, 32'h000F_0000);
      rd(12'h184, 1, 32'h0001_0000, "R5 clear-pending write needs grant>=2");
      wr(12'h284, 0, 32'h000F_000F);
      rd(12'h284, 1, 32'h0000_000F, "R4 active write uses group only");
      wr(12'h284, 1, 32'h0007_0000);
      rd(12'h284, 0, 32'h0006_000F, "R5 active read needs grant>=2");
      rd(12'h304, 1, 32'h0007_000F, "R1 active clear alias secure");
      sec_disable = 1;
      rd(12'h204, 0, 32'h0001_0000, "R4 disabled security full pending view");
      rd(12'h40C, 1, 32'h0, "R8 grant zero when security disabled");
      sec_disable = 0;

      // R6 level merge: word2 irqs 64..71 edge, 72 level
      wr(12'h388, 1, 32'h0000_00FF);
      rd(12'h388, 1, 32'h0000_00FF, "R1 trigger config readback");
      irq_lines[72] = 1; idle(2);
      rd(12'h188, 1, 32'h0000_0100, "R6 level line shows pending");
      chk(pend_o[72], 1'b1, "R10 merged pending output");
      rd(12'h188, 0, 32'h0, "R4 non-secure pending masked");
      irq_lines[72] = 0; idle(2);
      rd(12'h188, 1, 32'h0, "R6 level line not latched");

      // R7 edge latching
      irq_lines[64] = 1; idle(2);
      rd(12'h188, 1, 32'h0000_0001, "R7 rising edge latches");
      wr(12'h208, 1, 32'h0000_0001);
      idle(2);
      rd(12'h188, 1, 32'h0, "R7 steady high level does not relatch");
      irq_lines[64] = 0; idle(2);
      rd(12'h188, 1, 32'h0, "R7 falling edge no effect");
      // edge on the same clock as a clear of the same bit
      @(posedge clk); #1;
      req_valid = 1; req_write = 1; req_secure = 1; req_addr = 12'h208;
      req_wdata = 32'h0000_0002; irq_lines[65] = 1;
      @(posedge clk); #1;
      req_valid = 0; req_write = 0;
      rd(12'h188, 1, 32'h0000_0002, "R7 edge wins over same-cycle clear");

      // R2 grant word index limits, R9 unmapped
      wr(12'h400, 1, 32'hFFFF_FFFF);
      rd(12'h400, 1, 32'h0, "R2 grant word for internal irqs");
      rd(12'h418, 1, 32'h0, "R2 grant word beyond NUM_IRQ");
      rd(12'h500, 1, 32'h0, "R9 unmapped address");
      rd(12'h7FC, 1, 32'h0, "R9 top unmapped address");

      idle(3);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R9 missing responses: got %0d pending expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule